// File: doc/BRIEF.md
# Special-purpose register write unit

This unit executes the move-to-special-purpose-register instruction of a RISC core that has 32-bit instructions and 64-bit registers. Each cycle it can take one valid instruction word, the value already read from the source general-purpose register that the word names, and a flag that says whether the core runs in supervisor mode. It checks the opcode fields and recovers the register number, which the encoding stores with its two 5-bit halves swapped. It then updates one architectural register: the link register, the count register, the vector-save mask, the packed XER flags, one half of the 64-bit time base, or one of eight privileged kernel registers.

A write to a privileged target from problem state raises a one-cycle trap flag and changes nothing. A register number the unit does not know, or a word that is not this instruction, raises a one-cycle illegal flag and changes nothing. Every other valid word updates its target and advances the program counter by 4. All results appear one clock edge after the valid input. The unit also gives the source register index back, combinationally, so the core's register file can be addressed from it.

Top module: `spr_write_unit`

## Requirements
- R1: Bits are numbered with bit 0 as the MSB, so port bit `in_insn[31-k]` is bit k. A valid word is recognised only when bits 0–5 equal 31 and bits 21–30 equal 467. Any other valid word raises `illegal` and makes no write. Bit 31 (`in_insn[0]`) has no effect.
- R2: The register number is n = {f[4:0], f[9:5]}, where f = bits 11–20 (`in_insn[20:11]`).
- R3: When n = 8, all 64 bits of `in_rs_val` go to `lr`.
- R4: When n = 9, `ctr` takes the low 32 bits of `in_rs_val`, zero-extended, so `ctr[63:32]` is always 0.
- R5: When n = 256, `vrsave` takes `in_rs_val[31:0]`.
- R6: When n = 1, the XER fields load from the source: `xer_so` from bit 31, `xer_ov` from bit 30, `xer_ca` from bit 29 and `xer_len` from bits 6:0. All other source bits are discarded.
- R7: When n = 284, `tbase[31:0]` takes `in_rs_val[31:0]` and the upper half is kept. When n = 285, `tbase[63:32]` takes `in_rs_val[31:0]` and the lower half is kept. Both writes need `in_super` = 1. Otherwise they raise `priv_trap` and leave `tbase` unchanged.
- R8: The kernel registers use this index map into `kern_regs`: n = 18 → index 0, n = 19 → 1, n = 272..275 → 2..5, n = 1008 → 6, n = 1009 → 7. With `in_super` = 1 the selected entry takes the full 64-bit source. With `in_super` = 0 the unit raises `priv_trap`, no register changes and `pc` holds.
- R9: Any other n raises `illegal` for one cycle, makes no write and leaves `pc` unchanged.
- R10: Each valid input gives a one-cycle `done` pulse on the next clock edge, and there is no pulse without one. When the instruction succeeds (neither `illegal` nor `priv_trap`), `pc` advances by 4 on that same edge.
- R11: Reset clears `pc`, every target register and every output flag to zero.
- R12: `rs_sel` equals bits 6–10 (`in_insn[25:21]`), combinationally.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| in_rs_val | input | 64 | Value of the source register |
| in_super | input | 1 | 1 = supervisor mode, 0 = problem state |
| rs_sel | output | 5 | Source register index taken from the word |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction flag |
| priv_trap | output | 1 | One-cycle privileged-instruction trap flag |
| pc | output | 64 | Program counter |
| lr | output | 64 | Link register |
| ctr | output | 64 | Count register |
| vrsave | output | 32 | Vector-save mask |
| xer_so | output | 1 | Summary overflow |
| xer_ov | output | 1 | Overflow |
| xer_ca | output | 1 | Carry |
| xer_len | output | 7 | Byte count field |
| tbase | output | 64 | Time base |
| kern_regs | output | 8x64 | Kernel registers, indexed as in R8 |

## Verification
`rs_sel` is combinational, so it is checked in the same cycle its word is driven. Every other result, meaning `done`, both fault flags, `pc` and every target register, is due on the first rising edge after the valid cycle. The bench drives each word on a falling edge and drops `in_valid` on the next falling edge. It then samples every output at that falling edge, half a period after the result edge. After each vector it compares the whole register state against a model held in the bench. This also shows that faulting words and words aimed at other targets left every register alone.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int XLEN  = 64;
  localparam int HALF  = XLEN / 2;
  localparam int NKERN = 8;
  localparam int KIW   = $clog2(NKERN);
  localparam int LENW  = 7;

  localparam logic [5:0] OP_MAJOR = 6'd31;
  localparam logic [9:0] OP_MINOR = 10'd467;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_XER,
    TGT_LR,
    TGT_CTR,
    TGT_VRS,
    TGT_TBL,
    TGT_TBU,
    TGT_KERN
  } tgt_e;

  function automatic logic [9:0] spr_untwist(input logic [9:0] f);
    return {f[4:0], f[9:5]};
  endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
(
  input  logic [31:1]    insn,
  output tgt_e           tgt,
  output logic [KIW-1:0] kidx,
  output logic           priv,
  output logic [4:0]     rs_sel
);
  logic [9:0] num;
  logic       match;

  assign num    = spr_untwist(insn[20:11]);
  assign match  = (insn[31:26] == OP_MAJOR) && (insn[10:1] == OP_MINOR);
  assign rs_sel = insn[25:21];

  always_comb begin
    tgt  = TGT_NONE;
    kidx = '0;
    priv = 1'b0;
    if (match) begin
      case (num)
        10'd1:    tgt = TGT_XER;
        10'd8:    tgt = TGT_LR;
        10'd9:    tgt = TGT_CTR;
        10'd256:  tgt = TGT_VRS;
        10'd284:  begin tgt = TGT_TBL; priv = 1'b1; end
        10'd285:  begin tgt = TGT_TBU; priv = 1'b1; end
        10'd18:   begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(0); end
        10'd19:   begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(1); end
        10'd272:  begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(2); end
        10'd273:  begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(3); end
        10'd274:  begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(4); end
        10'd275:  begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(5); end
        10'd1008: begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(6); end
        10'd1009: begin tgt = TGT_KERN; priv = 1'b1; kidx = KIW'(7); end
        default:  tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spr_kernel_bank.sv
module spr_kernel_bank #(
  parameter int W   = 64,
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic         en;
    logic [W-1:0] d;

    always_comb begin
      en = we && (widx == IW'(i));
      d  = en ? wdata : q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/spr_timebase.sv
module spr_timebase #(
  parameter int W   = 64,
  localparam int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [HW-1:0] wdata,
  output logic [W-1:0]  q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    d = q;
    if (we_lo) d[HW-1:0] = wdata;
    if (we_hi) d[W-1:HW] = wdata;
    en = we_lo | we_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/spr_write_unit.sv
module spr_write_unit
  import spr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [31:0]                 in_insn,
  input  logic [XLEN-1:0]             in_rs_val,
  input  logic                        in_super,
  output logic [4:0]                  rs_sel,
  output logic                        done,
  output logic                        illegal,
  output logic                        priv_trap,
  output logic [XLEN-1:0]             pc,
  output logic [XLEN-1:0]             lr,
  output logic [XLEN-1:0]             ctr,
  output logic [HALF-1:0]             vrsave,
  output logic                        xer_so,
  output logic                        xer_ov,
  output logic                        xer_ca,
  output logic [LENW-1:0]             xer_len,
  output logic [XLEN-1:0]             tbase,
  output logic [NKERN-1:0][XLEN-1:0]  kern_regs
);
  // Reset: asynchronous assertion, release through two flops
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic unused_rsv;
  assign unused_rsv = in_insn[0];

  tgt_e           tgt;
  logic [KIW-1:0] kidx;
  logic           priv;

  spr_decode u_dec (
    .insn   (in_insn[31:1]),
    .tgt    (tgt),
    .kidx   (kidx),
    .priv   (priv),
    .rs_sel (rs_sel)
  );

  logic ok, f_ill, f_prv;
  always_comb begin
    f_ill = in_valid && (tgt == TGT_NONE);
    f_prv = in_valid && (tgt != TGT_NONE) && priv && !in_super;
    ok    = in_valid && !f_ill && !f_prv;
  end

  spr_timebase #(.W(XLEN)) u_tb (
    .clk   (clk),
    .rst_n (rst_sn),
    .we_lo (ok && (tgt == TGT_TBL)),
    .we_hi (ok && (tgt == TGT_TBU)),
    .wdata (in_rs_val[HALF-1:0]),
    .q     (tbase)
  );

  spr_kernel_bank #(.W(XLEN), .N(NKERN)) u_kern (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (ok && (tgt == TGT_KERN)),
    .widx  (kidx),
    .wdata (in_rs_val),
    .q     (kern_regs)
  );

  // Next state for the registers held directly in the top
  logic [XLEN-1:0] pc_d, lr_d, ctr_d;
  logic [HALF-1:0] vrs_d;
  logic            so_d, ov_d, ca_d;
  logic [LENW-1:0] len_d;
  logic            pc_en, lr_en, ctr_en, vrs_en, xer_en;

  always_comb begin
    pc_en  = ok;
    lr_en  = ok && (tgt == TGT_LR);
    ctr_en = ok && (tgt == TGT_CTR);
    vrs_en = ok && (tgt == TGT_VRS);
    xer_en = ok && (tgt == TGT_XER);
    pc_d   = pc + XLEN'(4);
    lr_d   = in_rs_val;
    ctr_d  = {{(XLEN-HALF){1'b0}}, in_rs_val[HALF-1:0]};
    vrs_d  = in_rs_val[HALF-1:0];
    so_d   = in_rs_val[31];
    ov_d   = in_rs_val[30];
    ca_d   = in_rs_val[29];
    len_d  = in_rs_val[LENW-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      priv_trap <= 1'b0;
      pc        <= '0;
      lr        <= '0;
      ctr       <= '0;
      vrsave    <= '0;
      xer_so    <= 1'b0;
      xer_ov    <= 1'b0;
      xer_ca    <= 1'b0;
      xer_len   <= '0;
    end else begin
      done      <= in_valid;
      illegal   <= f_ill;
      priv_trap <= f_prv;
      if (pc_en)  pc     <= pc_d;
      if (lr_en)  lr     <= lr_d;
      if (ctr_en) ctr    <= ctr_d;
      if (vrs_en) vrsave <= vrs_d;
      if (xer_en) begin
        xer_so  <= so_d;
        xer_ov  <= ov_d;
        xer_ca  <= ca_d;
        xer_len <= len_d;
      end
    end
  end
endmodule

// File: rtl/spr_write_unit_chk.sv
module spr_write_unit_chk
  import spr_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       done,
  input logic                       illegal,
  input logic                       priv_trap,
  input logic [XLEN-1:0]            pc,
  input logic [XLEN-1:0]            lr,
  input logic [XLEN-1:0]            ctr,
  input logic [HALF-1:0]            vrsave,
  input logic [XLEN-1:0]            tbase,
  input logic [NKERN-1:0][XLEN-1:0] kern_regs
);
  p_done_follows_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !priv_trap) |-> (pc == $past(pc) + XLEN'(4)));

  p_faults_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && priv_trap));

  p_fault_has_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || priv_trap) |-> done);

  p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(pc) && $stable(lr) && $stable(ctr) && $stable(vrsave)
                 && $stable(tbase) && $stable(kern_regs)));

  p_trap_kern_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_trap |-> ($stable(kern_regs) && $stable(pc)));

  p_trap_tb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_trap |-> $stable(tbase));

  p_ctr_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctr[XLEN-1:HALF] == '0);
endmodule

bind spr_write_unit spr_write_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .done      (done),
  .illegal   (illegal),
  .priv_trap (priv_trap),
  .pc        (pc),
  .lr        (lr),
  .ctr       (ctr),
  .vrsave    (vrsave),
  .tbase     (tbase),
  .kern_regs (kern_regs)
);

// File: tb/tb_spr_write_unit.sv
`timescale 1ns/1ps
module tb_spr_write_unit;
  import spr_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                       rst_n, in_valid, in_super;
  logic [31:0]                in_insn;
  logic [XLEN-1:0]            in_rs_val;
  logic [4:0]                 rs_sel;
  logic                       done, illegal, priv_trap;
  logic [XLEN-1:0]            pc, lr, ctr, tbase;
  logic [HALF-1:0]            vrsave;
  logic                       xer_so, xer_ov, xer_ca;
  logic [LENW-1:0]            xer_len;
  logic [NKERN-1:0][XLEN-1:0] kern_regs;

  spr_write_unit dut (.*);

  int errors = 0, checks = 0;

  // model state
  logic [63:0] m_pc, m_lr, m_ctr, m_tb;
  logic [31:0] m_vrs;
  logic [9:0]  m_xer;
  logic [7:0][63:0] m_k;

  typedef struct packed {
    logic [9:0]  spr;
    logic [63:0] val;
    logic        sup;
    logic        exp_ill;
    logic        exp_trap;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{10'd8,    64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0},
    '{10'd9,    64'hFFFF_FFFF_DEAD_BEEF, 1'b0, 1'b0, 1'b0},
    '{10'd256,  64'hAAAA_5555_1234_5678, 1'b0, 1'b0, 1'b0},
    '{10'd1,    64'hFFFF_FFFF_E000_007F, 1'b0, 1'b0, 1'b0},
    '{10'd1,    64'h0000_0000_4000_0085, 1'b0, 1'b0, 1'b0},
    '{10'd284,  64'h1111_1111_2222_2222, 1'b1, 1'b0, 1'b0},
    '{10'd285,  64'h9999_9999_3333_3333, 1'b1, 1'b0, 1'b0},
    '{10'd284,  64'h0000_0000_4444_4444, 1'b0, 1'b0, 1'b1},
    '{10'd285,  64'h0000_0000_5555_5555, 1'b0, 1'b0, 1'b1},
    '{10'd18,   64'hC0DE_0000_0000_0018, 1'b1, 1'b0, 1'b0},
    '{10'd272,  64'hC0DE_0000_0000_0110, 1'b1, 1'b0, 1'b0},
    '{10'd275,  64'hC0DE_0000_0000_0113, 1'b1, 1'b0, 1'b0},
    '{10'd1009, 64'hC0DE_0000_0000_03F1, 1'b1, 1'b0, 1'b0},
    '{10'd19,   64'hBAD0_BAD0_BAD0_BAD0, 1'b0, 1'b0, 1'b1},
    '{10'd1008, 64'hBAD1_BAD1_BAD1_BAD1, 1'b0, 1'b0, 1'b1},
    '{10'd2,    64'hBAD2_BAD2_BAD2_BAD2, 1'b1, 1'b1, 1'b0},
    '{10'd300,  64'hBAD3_BAD3_BAD3_BAD3, 1'b1, 1'b1, 1'b0},
    '{10'd8,    64'h7777_6666_5555_4444, 1'b1, 1'b0, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [9:0] spr, input logic [4:0] rsi,
                                     input logic [5:0] maj, input logic [9:0] mnr,
                                     input logic rsv);
    return {maj, rsi, spr[4:0], spr[9:5], mnr, rsv};
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " pc"}, pc, m_pc);
    chk({tag, " R3 lr"}, lr, m_lr);
    chk({tag, " R4 ctr"}, ctr, m_ctr);
    chk({tag, " R5 vrsave"}, {32'h0, vrsave}, {32'h0, m_vrs});
    chk({tag, " R6 xer"}, {54'h0, xer_so, xer_ov, xer_ca, xer_len}, {54'h0, m_xer});
    chk({tag, " R7 tbase"}, tbase, m_tb);
    for (int i = 0; i < 8; i++) chk({tag, " R8 kern"}, kern_regs[i], m_k[i]);
  endtask

  // issue one word: drive at negedge, sample at the following negedge
  task automatic issue(input logic [31:0] w, input logic [63:0] v, input logic s);
    in_insn = w; in_rs_val = v; in_super = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // model of the effect of a valid, recognised word (from the requirements)
  task automatic model(input logic [9:0] n, input logic [63:0] v, input logic s,
                       output logic ill, output logic trp);
    ill = 1'b0; trp = 1'b0;
    case (n)
      10'd8:   m_lr  = v;
      10'd9:   m_ctr = {32'h0, v[31:0]};
      10'd256: m_vrs = v[31:0];
      10'd1:   m_xer = {v[31], v[30], v[29], v[6:0]};
      10'd284: if (s) m_tb[31:0]  = v[31:0]; else trp = 1'b1;
      10'd285: if (s) m_tb[63:32] = v[31:0]; else trp = 1'b1;
      10'd18:  if (s) m_k[0] = v; else trp = 1'b1;
      10'd19:  if (s) m_k[1] = v; else trp = 1'b1;
      10'd272: if (s) m_k[2] = v; else trp = 1'b1;
      10'd273: if (s) m_k[3] = v; else trp = 1'b1;
      10'd274: if (s) m_k[4] = v; else trp = 1'b1;
      10'd275: if (s) m_k[5] = v; else trp = 1'b1;
      10'd1008: if (s) m_k[6] = v; else trp = 1'b1;
      10'd1009: if (s) m_k[7] = v; else trp = 1'b1;
      default: ill = 1'b1;
    endcase
    if (!ill && !trp) m_pc = m_pc + 64'd4;
  endtask

  task automatic model_reset();
    m_pc = '0; m_lr = '0; m_ctr = '0; m_tb = '0; m_vrs = '0; m_xer = '0; m_k = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ill, trp;
    in_valid = 1'b0; in_insn = '0; in_rs_val = '0; in_super = 1'b0;
    do_reset();

    // R11: reset state
    chk("R11 done", {63'h0, done}, 64'h0);
    chk("R11 illegal", {63'h0, illegal}, 64'h0);
    chk("R11 priv_trap", {63'h0, priv_trap}, 64'h0);
    chk_state("R11 reset");

    // R12: source index comes straight from bits 6-10
    in_insn = mk(10'd8, 5'd19, 6'd31, 10'd467, 1'b0);
    #1 chk("R12 rs_sel", {59'h0, rs_sel}, 64'd19);

    // vector walk: R2..R10
    for (int i = 0; i < NV; i++) begin
      issue(mk(VECS[i].spr, 5'(i), 6'd31, 10'd467, 1'b0), VECS[i].val, VECS[i].sup);
      model(VECS[i].spr, VECS[i].val, VECS[i].sup, ill, trp);
      chk("R10 done pulse", {63'h0, done}, 64'h1);
      chk("R9 illegal", {63'h0, illegal}, {63'h0, VECS[i].exp_ill});
      chk("R8 priv_trap", {63'h0, priv_trap}, {63'h0, VECS[i].exp_trap});
      chk("R2 model agrees with table", {62'h0, ill, trp},
          {62'h0, VECS[i].exp_ill, VECS[i].exp_trap});
      chk_state("R2 vector");
    end

    // R10: done lasts one cycle, nothing without valid
    @(negedge clk);
    chk("R10 no done when idle", {63'h0, done}, 64'h0);

    // R1: wrong major opcode
    issue(mk(10'd8, 5'd1, 6'd30, 10'd467, 1'b0), 64'hDEAD_0000_0000_0001, 1'b1);
    chk("R1 bad major illegal", {63'h0, illegal}, 64'h1);
    chk_state("R1 bad major");

    // R1: wrong minor opcode
    issue(mk(10'd9, 5'd1, 6'd31, 10'd339, 1'b0), 64'hDEAD_0000_0000_0002, 1'b1);
    chk("R1 bad minor illegal", {63'h0, illegal}, 64'h1);
    chk_state("R1 bad minor");

    // R1: reserved bit set changes nothing
    issue(mk(10'd8, 5'd2, 6'd31, 10'd467, 1'b1), 64'h0F0F_0F0F_0F0F_0F0F, 1'b0);
    model(10'd8, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, ill, trp);
    chk("R1 reserved bit ignored", {63'h0, illegal}, 64'h0);
    chk_state("R1 reserved");

    // R2: halves not symmetric: 256 must not look like 8
    issue(mk(10'd256, 5'd3, 6'd31, 10'd467, 1'b0), 64'h0000_0000_CAFE_F00D, 1'b0);
    model(10'd256, 64'h0000_0000_CAFE_F00D, 1'b0, ill, trp);
    chk_state("R2 transposed 256");

    // R11: reset mid-run clears everything
    do_reset();
    chk("R11 reset again done", {63'h0, done}, 64'h0);
    chk_state("R11 reset again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule